// File: doc/BRIEF.md
# Upper Memory Shadow Attribute Decoder

This block takes a physical address and two 32-bit attribute words and decides, separately for a read and for a write, whether the access goes to ROM or to shadow RAM. The address window it covers runs from 0xC0000 to 0xFFFFF. That window is split into 16 KB segments, and each segment picks up a 2-bit attribute field from one of the two words. The memory system uses the two output bits to steer an access either to the ROM image or to the RAM copy that sits over it. The attribute words live elsewhere and are only presented to this block.

The two attribute words are called the base word and the extension word. The base word is the one held at configuration offset 0x58. The extension word is the one held at offset 0x5C.

The segments from 0xC0000 to 0xCFFFF take their fields from the upper half of the base word. The eight segments from 0xD0000 to 0xEFFFF take theirs from the extension word. The top 64 KB, 0xF0000 to 0xFFFFF, has one field that all four of its segments share, held in the base word.

A read and a write decode different bits of the same field. An address outside the window raises an error flag.

The decode is purely combinational and holds no state.

Top module: `shdw_region_decoder`

## Requirements
- R1: When address bits 19:18 are not both 1, so that the masked address is below 0xC0000, `addr_err` is 1 and both `rd_to_rom` and `wr_to_rom` are 0. When those bits are both 1, `addr_err` is 0.
- R2: Address bits above bit 19 and bits 13:0 have no effect on any output. For example, 0x1C0000 and 0xC3FFF decode exactly as 0xC0000 does.
- R3: For addresses 0xC0000 to 0xCFFFF, the field is `attr_base` bits [17+4k:16+4k], where k = address bits 15:14.
- R4: For addresses 0xD0000 to 0xEFFFF, the field is `attr_ext` bits [1+4k:4k], where k = (address bits 17:14) minus 4.
- R5: All addresses 0xF0000 to 0xFFFFF use the single field `attr_base` bits 13:12.
- R6: `rd_to_rom` is 1 (ROM) when field bit 0 is 0, that is for field values 0 and 2. It is 0 (shadow RAM) for field values 1 and 3.
- R7: `wr_to_rom` is 1 (ROM) when field bit 1 is 0, that is for field values 0 and 1. It is 0 (shadow RAM) for field values 2 and 3.
- R8: Attribute bits outside the selected field, including the whole of the word that is not selected, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phys_addr | input | ADDR_W (32) | Physical address of the access |
| attr_base | input | ATTR_W (32) | Attribute word from offset 0x58 |
| attr_ext | input | ATTR_W (32) | Attribute word from offset 0x5C |
| rd_to_rom | output | 1 | Read target: 1 = ROM, 0 = shadow RAM |
| wr_to_rom | output | 1 | Write target: 1 = ROM, 0 = shadow RAM |
| addr_err | output | 1 | The address lies outside the window |

## Verification
The assertions are evaluated every time the inputs settle. They check four things:
- an error always forces both target bits low;
- the error flag follows address bits 19:18 exactly;
- the shared top field drives both targets anywhere in 0xF0000 to 0xFFFFF;
- the first segment follows its own field bits.

Only the bench scenarios can show the rest:
- that each segment reads from the right word and bit offset;
- that unrelated attribute bits are masked;
- that the aliasing of the upper and lower address bits works as required.

// File: rtl/shdw_pkg.sv
package shdw_pkg;

   // Target encoding shared by both outputs
   typedef enum logic {
      TGT_SHADOW = 1'b0,
      TGT_ROM    = 1'b1
   } shdw_tgt_e;

   // Read decode: field bit 0 clear selects ROM
   function automatic shdw_tgt_e read_target(input logic [1:0] fld);
      return fld[0] ? TGT_SHADOW : TGT_ROM;
   endfunction

   // Write decode: field bit 1 clear selects ROM
   function automatic shdw_tgt_e write_target(input logic [1:0] fld);
      return fld[1] ? TGT_SHADOW : TGT_ROM;
   endfunction

endpackage

// File: rtl/shdw_seg_index.sv
module shdw_seg_index #(
   parameter int ADDR_W   = 32,
   parameter int SEG_LSB  = 14,
   parameter int SEG_BITS = 4,
   parameter int WIN_BITS = 2
) (
   input  logic [ADDR_W-1:0]   addr,
   output logic [SEG_BITS-1:0] seg_idx,
   output logic                in_window
);
   localparam int TOP_BIT = SEG_LSB + SEG_BITS + WIN_BITS;

   if (ADDR_W < TOP_BIT) begin : g_bad_width
      $error("shdw_seg_index: ADDR_W too narrow for window");
   end

   assign seg_idx   = addr[SEG_LSB +: SEG_BITS];
   assign in_window = &addr[SEG_LSB+SEG_BITS +: WIN_BITS];

   // Bits below the segment and above the window do not take part in the decode
   logic unused_low;
   assign unused_low = ^addr[SEG_LSB-1:0];

   if (ADDR_W > TOP_BIT) begin : g_hi
      logic unused_high;
      assign unused_high = ^addr[ADDR_W-1:TOP_BIT];
   end
endmodule

// File: rtl/shdw_field_mux.sv
module shdw_field_mux #(
   parameter int ATTR_W    = 32,
   parameter int FIELD_W   = 2,
   parameter int STRIDE    = 4,
   parameter int LO_SEGS   = 4,
   parameter int LO_OFS    = 16,
   parameter int EXT_SEGS  = 8,
   parameter int TOP_OFS   = 12,
   parameter int SEG_BITS  = 4
) (
   input  logic [ATTR_W-1:0]   attr_base,
   input  logic [ATTR_W-1:0]   attr_ext,
   input  logic [SEG_BITS-1:0] seg_idx,
   output logic [FIELD_W-1:0]  field
);
   localparam int SEG_COUNT = 1 << SEG_BITS;
   localparam int TOP_START = LO_SEGS + EXT_SEGS;

   if (LO_OFS + STRIDE*(LO_SEGS-1) + FIELD_W > ATTR_W) begin : g_bad_lo
      $error("shdw_field_mux: low fields overflow base word");
   end
   if (STRIDE*(EXT_SEGS-1) + FIELD_W > ATTR_W) begin : g_bad_ext
      $error("shdw_field_mux: ext fields overflow ext word");
   end
   if (TOP_START > SEG_COUNT) begin : g_bad_cnt
      $error("shdw_field_mux: segment count too small");
   end

   logic [FIELD_W-1:0] seg_field [SEG_COUNT];

   for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
      if (s < LO_SEGS) begin : g_lo
         assign seg_field[s] = attr_base[LO_OFS + STRIDE*s +: FIELD_W];
      end else if (s < TOP_START) begin : g_ext
         assign seg_field[s] = attr_ext[STRIDE*(s-LO_SEGS) +: FIELD_W];
      end else begin : g_top
         assign seg_field[s] = attr_base[TOP_OFS +: FIELD_W];
      end
   end

   assign field = seg_field[seg_idx];
endmodule

// File: rtl/shdw_route_map.sv
module shdw_route_map
   import shdw_pkg::*;
(
   input  logic [1:0] field,
   input  logic       in_window,
   output logic       rd_rom,
   output logic       wr_rom,
   output logic       err
);
   always_comb begin
      if (in_window) begin
         rd_rom = (read_target(field)  == TGT_ROM);
         wr_rom = (write_target(field) == TGT_ROM);
         err    = 1'b0;
      end else begin
         rd_rom = 1'b0;
         wr_rom = 1'b0;
         err    = 1'b1;
      end
   end
endmodule

// File: rtl/shdw_region_decoder.sv
module shdw_region_decoder #(
   parameter int ADDR_W = 32,
   parameter int ATTR_W = 32
) (
   input  logic [ADDR_W-1:0] phys_addr,
   input  logic [ATTR_W-1:0] attr_base,
   input  logic [ATTR_W-1:0] attr_ext,
   output logic              rd_to_rom,
   output logic              wr_to_rom,
   output logic              addr_err
);
   localparam int FIELD_W  = 2;
   localparam int SEG_LSB  = 14;
   localparam int SEG_BITS = 4;

   logic [SEG_BITS-1:0] seg_idx;
   logic                in_window;
   logic [FIELD_W-1:0]  field;

   shdw_seg_index #(
      .ADDR_W  (ADDR_W),
      .SEG_LSB (SEG_LSB),
      .SEG_BITS(SEG_BITS),
      .WIN_BITS(2)
   ) u_index (
      .addr     (phys_addr),
      .seg_idx  (seg_idx),
      .in_window(in_window)
   );

   shdw_field_mux #(
      .ATTR_W  (ATTR_W),
      .FIELD_W (FIELD_W),
      .STRIDE  (4),
      .LO_SEGS (4),
      .LO_OFS  (16),
      .EXT_SEGS(8),
      .TOP_OFS (12),
      .SEG_BITS(SEG_BITS)
   ) u_mux (
      .attr_base(attr_base),
      .attr_ext (attr_ext),
      .seg_idx  (seg_idx),
      .field    (field)
   );

   shdw_route_map u_route (
      .field    (field),
      .in_window(in_window),
      .rd_rom   (rd_to_rom),
      .wr_rom   (wr_to_rom),
      .err      (addr_err)
   );
endmodule

// File: rtl/shdw_region_decoder_chk.sv
module shdw_region_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int ATTR_W = 32
) (
   input logic [ADDR_W-1:0] phys_addr,
   input logic [ATTR_W-1:0] attr_base,
   input logic [ATTR_W-1:0] attr_ext,
   input logic              rd_to_rom,
   input logic              wr_to_rom,
   input logic              addr_err
);
   logic unused_ext;
   assign unused_ext = ^attr_ext;

   always_comb begin
      AST_ERR_QUIET: assert (!(addr_err && (rd_to_rom || wr_to_rom)))
         else $error("error with target asserted"); // R1
      AST_ERR_WINDOW: assert (addr_err == !(phys_addr[19] && phys_addr[18]))
         else $error("error flag mismatch"); // R1
      AST_TOP_SHARED_RD: assert (!(phys_addr[19:16] == 4'hF) || (rd_to_rom == !attr_base[12]))
         else $error("top read field mismatch"); // R5
      AST_TOP_SHARED_WR: assert (!(phys_addr[19:16] == 4'hF) || (wr_to_rom == !attr_base[13]))
         else $error("top write field mismatch"); // R5
      AST_FIRST_SEG: assert (!(phys_addr[19:14] == 6'h30) || (rd_to_rom == !attr_base[16] && wr_to_rom == !attr_base[17]))
         else $error("first segment mismatch"); // R3
   end
endmodule

bind shdw_region_decoder shdw_region_decoder_chk #(
   .ADDR_W(ADDR_W),
   .ATTR_W(ATTR_W)
) u_chk (
   .phys_addr(phys_addr),
   .attr_base(attr_base),
   .attr_ext (attr_ext),
   .rd_to_rom(rd_to_rom),
   .wr_to_rom(wr_to_rom),
   .addr_err (addr_err)
);

// File: tb/shdw_region_decoder_bench.sv
module shdw_region_decoder_bench;
   logic        clk = 1'b0;
   logic [31:0] phys_addr = '0;
   logic [31:0] attr_base = '0;
   logic [31:0] attr_ext  = '0;
   logic        rd_to_rom, wr_to_rom, addr_err;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   shdw_region_decoder u_shdw_region_decoder (
      .phys_addr(phys_addr),
      .attr_base(attr_base),
      .attr_ext (attr_ext),
      .rd_to_rom(rd_to_rom),
      .wr_to_rom(wr_to_rom),
      .addr_err (addr_err)
   );

   localparam int NV = 16;
   // {addr, base, ext, {err, rd, wr}}
   localparam logic [98:0] VEC [NV] = '{
      {32'h000C0000, 32'h00010000, 32'h0, 3'b001}, // R3 R6: field 1
      {32'h000C4000, 32'h00200000, 32'h0, 3'b010}, // R3 R7: field 2
      {32'h000CC123, 32'h30000000, 32'h0, 3'b000}, // R3: field 3
      {32'h000C8000, 32'hFCFFFFFF, 32'hFFFFFFFF, 3'b011}, // R8: only 25:24 count
      {32'h000D0000, 32'h0, 32'h00000001, 3'b001}, // R4
      {32'h000D4000, 32'h0, 32'h00000020, 3'b010}, // R4
      {32'h000EC000, 32'h0, 32'h30000000, 3'b000}, // R4
      {32'h000E0000, 32'hFFFFFFFF, 32'hFFFCFFFF, 3'b011}, // R8
      {32'h000F0000, 32'h00001000, 32'h0, 3'b001}, // R5
      {32'h000FFFFF, 32'h00001000, 32'h0, 3'b001}, // R5
      {32'h000F8000, 32'h00002000, 32'h0, 3'b010}, // R5
      {32'h000BFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'b100}, // R1
      {32'h00000000, 32'h0, 32'h0, 3'b100}, // R1
      {32'h001C0000, 32'h00010000, 32'h0, 3'b001}, // R2: bit 20 ignored
      {32'h000C3FFF, 32'h00010000, 32'h0, 3'b001}, // R2: low bits ignored
      {32'h00080000, 32'hFFFFFFFF, 32'h0, 3'b100}  // R1: bit 18 clear
   };

   task automatic check(input string req, input logic [2:0] exp);
      logic [2:0] act;
      act = {addr_err, rd_to_rom, wr_to_rom};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s addr=%h actual=%b expected=%b", req, phys_addr, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] e, input string req,
                        input logic [2:0] exp);
      @(negedge clk);
      {phys_addr, attr_base, attr_ext} = {a, b, e};
      @(posedge clk);
      #1;
      check(req, exp);
   endtask

   initial begin
      // Start-up state: all inputs zero lies below the window (R1)
      @(posedge clk);
      #1;
      check("R1", 3'b100);
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][98:67], VEC[i][66:35], VEC[i][34:3], "vector", VEC[i][2:0]);
      end
      // R8: a fully set extension word leaves the top region alone
      apply(32'h000F0000, 32'h0, 32'hFFFFFFFF, "R8", 3'b011);
      // R6 R7: field 3 in the last extension segment sends both to shadow
      apply(32'h000EFFFF, 32'h0, 32'h30000000, "R6", 3'b000);
      // R7: field 1 keeps writes in ROM and reads in shadow
      apply(32'h000CC000, 32'h10000000, 32'h0, "R7", 3'b001);
      // R2: top address bits alias into the top region
      apply(32'hFFFFFFFF, 32'h00003000, 32'h0, "R2", 3'b000);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 10000 && !done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule